// File: doc/BRIEF.md
# Four-Bank DDR Command Decoder and Bank Tracker

This block is the command front end of a four-bank double-data-rate SDRAM model. On every rising clock edge it samples clock enable, the active-low select and the three row/column/write strobes, two bank bits and a 14-bit address. From these it works out the command, keeps a per-bank record of whether a row is open, stores the two mode op-codes, and follows the device through its power states: running, power-down with all banks idle, power-down with a row open, and self refresh.

All results are registered. The outputs seen after an edge describe the command sampled at that edge. The decoded command, target bank, row, column and auto-precharge flag are reported, along with the bank-open vector, both mode words, the power state and a one-cycle illegal-command pulse. The data path, strobe timing, refresh counting and electrical behaviour are not modelled.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: When select is sampled high, the command is a no-operation: cmd_o reports 0 and no bank or mode state changes.
- R2: With select low and clock enable high in the running state, the strobe triple {ras_n,cas_n,we_n} decodes as 111 no-op (cmd_o 0), 011 activate (1), 101 read (2), 100 write (3), 010 precharge (4), 001 auto refresh (5), 000 mode load (7), 110 burst stop (8).
- R3: An activate to an idle bank opens that bank (bit ba of bank_open_o), sets bank_o to ba and sets row_o to the address.
- R4: A read or write sets bank_o to ba, sets col_o to the address with bit 10 forced to 0, and sets ap_o to address bit 10. ap_o is 0 after every other edge.
- R5: A precharge with address bit 10 low closes only bank ba. With bit 10 high it closes every bank.
- R6: An activate to an open bank, or a read or write to an idle bank, pulses illegal_o for one cycle and changes no bank state.
- R7: A read or write to an open bank with address bit 10 high closes that bank BURST_LEN running-state edges after the command edge.
- R8: A mode load with ba = 0 writes mode_o, and with ba = 1 writes ext_mode_o. With ba = 2 or 3 it writes neither.
- R9: Clock enable sampled low in the running state enters pstate_o 1 (power-down, idle) if every bank is idle, and pstate_o 2 (power-down, row open) otherwise.
- R10: An auto-refresh code sampled with clock enable low and all banks idle enters pstate_o 3 (self refresh) and reports cmd_o 6. With any bank open it pulses illegal_o and enters pstate_o 2.
- R11: Outside the running state, every command is ignored (cmd_o 0, no state change). The edge that samples clock enable high returns to pstate_o 0, and that edge's command is also ignored. Bank states held before entry are kept.
- R12: Clock enable sampled low within BURST_LEN edges after a legal read or write, with no burst stop in between, pulses illegal_o.
- R13: After reset: cmd_o 0, pstate_o 0, all banks idle, both mode words 0, illegal_o 0, and bank_o, row_o, col_o, ap_o all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Active-low select |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | 14 | Row, column or op-code bits |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Bank of the last banked command |
| row_o | output | 14 | Row of the last activate |
| col_o | output | 14 | Column of the last read or write |
| ap_o | output | 1 | Auto-precharge flag of this edge's read or write |
| bank_open_o | output | 4 | One bit per bank, 1 when a row is open |
| mode_o | output | 14 | Mode op-code |
| ext_mode_o | output | 14 | Extended mode op-code |
| pstate_o | output | 2 | Power state |
| illegal_o | output | 1 | One-cycle illegal-command pulse |

## Verification
A wrong bank record appears at bank_open_o one cycle after the edge that corrupted it. It spreads later, as a spurious or missing illegal pulse on the next activate, read or write to that bank, and as the wrong choice between the two power-down states. An auto-precharge timer that is off by one moves the bank-open clear by exactly one cycle. A stuck burst count shows up only when clock enable falls, as a missing or extra illegal pulse. Because of this, the stimulus mixes clock-enable drops with reads, writes and bursts, and compares every output on every cycle.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
   typedef enum logic [3:0] {
      CMD_NOP   = 4'd0,
      CMD_ACT   = 4'd1,
      CMD_READ  = 4'd2,
      CMD_WRITE = 4'd3,
      CMD_PRE   = 4'd4,
      CMD_REF   = 4'd5,
      CMD_SREF  = 4'd6,
      CMD_LMR   = 4'd7,
      CMD_BST   = 4'd8
   } cmd_e;

   typedef enum logic [1:0] {
      PS_RUN     = 2'd0,
      PS_PD_IDLE = 2'd1,
      PS_PD_OPEN = 2'd2,
      PS_SREF    = 2'd3
   } pstate_e;

   function automatic logic is_rw(cmd_e c);
      return (c == CMD_READ) || (c == CMD_WRITE);
   endfunction
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_cmd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd_o
);
   always_comb begin
      cmd_o = CMD_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd_o = CMD_ACT;
            3'b101:  cmd_o = CMD_READ;
            3'b100:  cmd_o = CMD_WRITE;
            3'b010:  cmd_o = CMD_PRE;
            3'b001:  cmd_o = CMD_REF;
            3'b000:  cmd_o = CMD_LMR;
            3'b110:  cmd_o = CMD_BST;
            default: cmd_o = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
   import ddr_cmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BURST_LEN = 4,
   parameter int BA_W      = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  cmd_e                 cmd,
   input  logic [BA_W-1:0]      ba,
   input  logic                 a10,
   output logic [NUM_BANKS-1:0] open_o,
   output logic                 all_idle_o,
   output logic                 illegal_o,
   output logic                 busy_o
);
   localparam int TW = $clog2(BURST_LEN + 1);

   logic sel_open;
   logic rw_ok;

   assign sel_open   = open_o[ba];
   assign rw_ok      = is_rw(cmd) && sel_open;
   assign all_idle_o = (open_o == '0);
   assign illegal_o  = step && (((cmd == CMD_ACT) && sel_open) ||
                                (is_rw(cmd) && !sel_open));

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic          open_q, open_d, hit;
      logic [TW-1:0] tmr_q, tmr_d;

      assign hit = (ba == BA_W'(g));

      always_comb begin
         open_d = open_q;
         tmr_d  = tmr_q;
         if (tmr_q != '0) begin
            tmr_d = tmr_q - 1'b1;
            if (tmr_q == TW'(1)) open_d = 1'b0;
         end
         if ((cmd == CMD_ACT) && hit && !open_q) open_d = 1'b1;
         if (is_rw(cmd) && hit && open_q && a10) begin
            open_d = 1'b1;
            tmr_d  = TW'(BURST_LEN);
         end
         if ((cmd == CMD_PRE) && (a10 || hit)) begin
            open_d = 1'b0;
            tmr_d  = '0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_q <= 1'b0;
            tmr_q  <= '0;
         end else if (step) begin
            open_q <= open_d;
            tmr_q  <= tmr_d;
         end
      end

      assign open_o[g] = open_q;
   end

   logic [TW-1:0] burst_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_q <= '0;
      end else if (step) begin
         if (rw_ok)                 burst_q <= TW'(BURST_LEN);
         else if (cmd == CMD_BST)   burst_q <= '0;
         else if (burst_q != '0)    burst_q <= burst_q - 1'b1;
      end
   end
   assign busy_o = (burst_q != '0);
endmodule

// File: rtl/ddr_mode_regs.sv
module ddr_mode_regs #(
   parameter int ADDR_W = 14,
   parameter int BA_W   = 2,
   parameter int NUM_MR = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [BA_W-1:0]               sel,
   input  logic [ADDR_W-1:0]             opcode,
   output logic [NUM_MR-1:0][ADDR_W-1:0] regs_o
);
   for (genvar m = 0; m < NUM_MR; m++) begin : g_mr
      always_ff @(posedge clk) begin
         if (!rst_n)                          regs_o[m] <= '0;
         else if (load && (sel == BA_W'(m)))  regs_o[m] <= opcode;
      end
   end
endmodule

// File: rtl/ddr_power_ctl.sv
module ddr_power_ctl
   import ddr_cmd_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cke,
   input  logic    ref_code,
   input  logic    all_idle,
   output pstate_e ps_o,
   output logic    sref_enter_o
);
   pstate_e ps_d;

   assign sref_enter_o = (ps_o == PS_RUN) && !cke && ref_code && all_idle;

   always_comb begin
      ps_d = ps_o;
      if (ps_o == PS_RUN) begin
         if (!cke) begin
            if (sref_enter_o)  ps_d = PS_SREF;
            else if (all_idle) ps_d = PS_PD_IDLE;
            else               ps_d = PS_PD_OPEN;
         end
      end else if (cke) begin
         ps_d = PS_RUN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ps_o <= PS_RUN;
      else        ps_o <= ps_d;
   end
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
   import ddr_cmd_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int NUM_BANKS = 4,
   parameter int BURST_LEN = 4,
   parameter int AP_BIT    = 10,
   parameter int NUM_MR    = 2,
   parameter int BA_W      = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BA_W-1:0]      ba,
   input  logic [ADDR_W-1:0]    addr,
   output logic [3:0]           cmd_o,
   output logic [BA_W-1:0]      bank_o,
   output logic [ADDR_W-1:0]    row_o,
   output logic [ADDR_W-1:0]    col_o,
   output logic                 ap_o,
   output logic [NUM_BANKS-1:0] bank_open_o,
   output logic [ADDR_W-1:0]    mode_o,
   output logic [ADDR_W-1:0]    ext_mode_o,
   output logic [1:0]           pstate_o,
   output logic                 illegal_o
);
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must index an address bit");
   end
   if (BURST_LEN < 1) begin : g_bad_bl
      $error("BURST_LEN must be at least 1");
   end
   if (NUM_MR < 2 || NUM_MR > NUM_BANKS) begin : g_bad_mr
      $error("NUM_MR must be between 2 and NUM_BANKS");
   end
   if (NUM_BANKS != (1 << BA_W)) begin : g_bad_nb
      $error("NUM_BANKS must be a power of two matching BA_W");
   end

   localparam logic [ADDR_W-1:0] COL_MASK = ~(ADDR_W'(1) << AP_BIT);

   cmd_e    raw_cmd, exec_cmd, rep_cmd;
   pstate_e ps;
   logic    run, exec, drop, a10;
   logic    all_idle, bank_bad, busy, sref_enter;
   logic    ill_d;
   logic [NUM_MR-1:0][ADDR_W-1:0] mr;

   ddr_cmd_decode u_dec (
      .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .cmd_o(raw_cmd)
   );

   assign run      = (ps == PS_RUN);
   assign exec     = run && cke;
   assign drop     = run && !cke;
   assign a10      = addr[AP_BIT];
   assign exec_cmd = exec ? raw_cmd : CMD_NOP;

   ddr_bank_tracker #(
      .NUM_BANKS(NUM_BANKS), .BURST_LEN(BURST_LEN), .BA_W(BA_W)
   ) u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (exec),
      .cmd       (exec_cmd),
      .ba        (ba),
      .a10       (a10),
      .open_o    (bank_open_o),
      .all_idle_o(all_idle),
      .illegal_o (bank_bad),
      .busy_o    (busy)
   );

   ddr_power_ctl u_pwr (
      .clk         (clk),
      .rst_n       (rst_n),
      .cke         (cke),
      .ref_code    (raw_cmd == CMD_REF),
      .all_idle    (all_idle),
      .ps_o        (ps),
      .sref_enter_o(sref_enter)
   );

   ddr_mode_regs #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .NUM_MR(NUM_MR)
   ) u_mr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (exec_cmd == CMD_LMR),
      .sel   (ba),
      .opcode(addr),
      .regs_o(mr)
   );

   assign mode_o     = mr[0];
   assign ext_mode_o = mr[1];
   assign pstate_o   = ps;

   assign rep_cmd = sref_enter ? CMD_SREF : exec_cmd;
   assign ill_d   = bank_bad ||
                    (drop && busy) ||
                    (drop && (raw_cmd == CMD_REF) && !all_idle);

   cmd_e cmd_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q     <= CMD_NOP;
         bank_o    <= '0;
         row_o     <= '0;
         col_o     <= '0;
         ap_o      <= 1'b0;
         illegal_o <= 1'b0;
      end else begin
         cmd_q     <= rep_cmd;
         illegal_o <= ill_d;
         ap_o      <= is_rw(exec_cmd) && a10;
         unique case (exec_cmd)
            CMD_ACT: begin
               bank_o <= ba;
               row_o  <= addr;
            end
            CMD_READ, CMD_WRITE: begin
               bank_o <= ba;
               col_o  <= addr & COL_MASK;
            end
            CMD_PRE, CMD_LMR: bank_o <= ba;
            default: ;
         endcase
      end
   end
   assign cmd_o = cmd_q;
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk #(
   parameter int ADDR_W    = 14,
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cke,
   input logic                 cs_n,
   input logic                 ras_n,
   input logic                 cas_n,
   input logic                 we_n,
   input logic [BA_W-1:0]      ba,
   input logic [ADDR_W-1:0]    addr,
   input logic [3:0]           cmd_o,
   input logic                 ap_o,
   input logic [NUM_BANKS-1:0] bank_open_o,
   input logic [ADDR_W-1:0]    mode_o,
   input logic [ADDR_W-1:0]    ext_mode_o,
   input logic [1:0]           pstate_o,
   input logic                 illegal_o
);
   logic live;
   assign live = (pstate_o == 2'd0) && cke && !cs_n;

   assert_cs_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (cmd_o == 4'd0));

   assert_act_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live && ({ras_n, cas_n, we_n} == 3'b011) && bank_open_o[ba]) |=> illegal_o);

   assert_pre_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (live && ({ras_n, cas_n, we_n} == 3'b010) && addr[10]) |=> (bank_open_o == '0));

   assert_pd_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate_o != 2'd0) |=> ($stable(bank_open_o) && $stable(mode_o) && $stable(ext_mode_o)));

   assert_sref_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate_o == 2'd3) |-> (bank_open_o == '0));

   assert_pd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate_o == 2'd1) |-> (bank_open_o == '0));

   assert_ap_rw_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ap_o |-> ((cmd_o == 4'd2) || (cmd_o == 4'd3)));
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
   .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BA_W(BA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
   .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
   .ap_o(ap_o), .bank_open_o(bank_open_o), .mode_o(mode_o),
   .ext_mode_o(ext_mode_o), .pstate_o(pstate_o), .illegal_o(illegal_o)
);

// File: tb/ddr_cmd_tracker_bench.sv
module ddr_cmd_tracker_bench;
   localparam int CLK_PERIOD = 10;
   localparam int BL         = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [13:0] addr = '0;
   logic [3:0]  cmd_o;
   logic [1:0]  bank_o, pstate_o;
   logic [13:0] row_o, col_o, mode_o, ext_mode_o;
   logic [3:0]  bank_open_o;
   logic        ap_o, illegal_o;

   int n_run = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr_cmd_tracker u_ddr_cmd_tracker (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
      .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .ap_o(ap_o),
      .bank_open_o(bank_open_o), .mode_o(mode_o), .ext_mode_o(ext_mode_o),
      .pstate_o(pstate_o), .illegal_o(illegal_o)
   );

   // expected-state model built from the requirements
   bit          m_open [4];
   int          m_tmr  [4];
   int          m_burst, m_ps, m_cmd;
   logic [1:0]  m_bank;
   logic [13:0] m_row, m_col, m_mr, m_ext;
   bit          m_ap, m_ill;

   function automatic int dec(bit c, bit [2:0] rcw);
      if (c) return 0;
      case (rcw)
         3'b011: return 1;
         3'b101: return 2;
         3'b100: return 3;
         3'b010: return 4;
         3'b001: return 5;
         3'b000: return 7;
         3'b110: return 8;
         default: return 0;
      endcase
   endfunction

   task automatic model_reset();
      foreach (m_open[i]) begin m_open[i] = 0; m_tmr[i] = 0; end
      m_burst = 0; m_ps = 0; m_cmd = 0; m_bank = 0; m_row = 0; m_col = 0;
      m_mr = 0; m_ext = 0; m_ap = 0; m_ill = 0;
   endtask

   task automatic model_step(bit k, bit c, bit [2:0] rcw, bit [1:0] b, bit [13:0] a);
      int  raw  = dec(c, rcw);
      bit  run  = (m_ps == 0);
      bit  idle = !(m_open[0] || m_open[1] || m_open[2] || m_open[3]);
      bit  rw   = (raw == 2) || (raw == 3);
      bit  ill  = 0;
      int  ncmd = 0;
      m_ap = 0;
      if (run && k) begin
         bit rw_ok = rw && m_open[b];
         ncmd = raw;
         if ((raw == 1 && m_open[b]) || (rw && !m_open[b])) ill = 1;
         for (int i = 0; i < 4; i++) begin
            bit o = m_open[i]; int t = m_tmr[i]; bit hit = (b == i);
            bit no = o; int nt = t;
            if (t != 0) begin nt = t - 1; if (t == 1) no = 0; end
            if (raw == 1 && hit && !o) no = 1;
            if (rw && hit && o && a[10]) begin no = 1; nt = BL; end
            if (raw == 4 && (a[10] || hit)) begin no = 0; nt = 0; end
            m_open[i] = no; m_tmr[i] = nt;
         end
         if (rw_ok)              m_burst = BL;
         else if (raw == 8)      m_burst = 0;
         else if (m_burst != 0)  m_burst--;
         if (raw == 1 || rw || raw == 4 || raw == 7) m_bank = b;
         if (raw == 1) m_row = a;
         if (rw) begin m_col = a & ~14'h0400; m_ap = a[10]; end
         if (raw == 7 && b == 0) m_mr  = a;
         if (raw == 7 && b == 1) m_ext = a;
      end else if (run && !k) begin
         if (m_burst != 0) ill = 1;
         if (raw == 5 && !idle) ill = 1;
         if (raw == 5 && idle) begin m_ps = 3; ncmd = 6; end
         else m_ps = idle ? 1 : 2;
      end else if (k) begin
         m_ps = 0;
      end
      m_cmd = ncmd; m_ill = ill;
   endtask

   task automatic chk(string tag, string fld, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, fld, act, exp);
      end
   endtask

   task automatic compare(string tag);
      int ov = {m_open[3], m_open[2], m_open[1], m_open[0]};
      chk(tag, "cmd R2",       cmd_o,       m_cmd);
      chk(tag, "open R3",      bank_open_o, ov);
      chk(tag, "pstate R9",    pstate_o,    m_ps);
      chk(tag, "illegal R6",   illegal_o,   m_ill);
      chk(tag, "bank R3",      bank_o,      m_bank);
      chk(tag, "row R3",       row_o,       m_row);
      chk(tag, "col R4",       col_o,       m_col);
      chk(tag, "ap R4",        ap_o,        m_ap);
      chk(tag, "mode R8",      mode_o,      m_mr);
      chk(tag, "ext R8",       ext_mode_o,  m_ext);
   endtask

   task automatic step(bit k, bit c, bit [2:0] rcw, bit [1:0] b, bit [13:0] a, string tag);
      @(negedge clk);
      cke = k; cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
      model_step(k, c, rcw, b, a);
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   localparam bit [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                        PRE = 3'b010, REF = 3'b001, LMR = 3'b000, BST = 3'b110;

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL R13 watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_2024));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1 compare("R13");

      step(1, 1, ACT, 1, 14'h1ABC, "R1");       // deselected: nothing opens
      step(1, 0, ACT, 1, 14'h1ABC, "R3");
      step(1, 0, ACT, 1, 14'h0001, "R6");       // already open
      step(1, 0, RD,  2, 14'h0011, "R6");       // idle bank
      step(1, 0, WR,  1, 14'h0123, "R4");
      step(1, 0, NOP, 0, 14'h0000, "R2");
      step(1, 0, BST, 0, 14'h0000, "R2");
      step(1, 0, LMR, 0, 14'h0031, "R8");
      step(1, 0, LMR, 1, 14'h0002, "R8");
      step(1, 0, LMR, 2, 14'h3FFF, "R8");       // ignored
      step(1, 0, ACT, 0, 14'h0200, "R3");
      step(0, 0, NOP, 0, 14'h0000, "R9");       // rows open -> pd open
      step(0, 0, PRE, 0, 14'h0400, "R11");      // ignored in power-down
      step(1, 0, PRE, 0, 14'h0400, "R11");      // exit edge, ignored
      step(1, 0, PRE, 0, 14'h0000, "R5");       // single bank 0
      step(1, 0, PRE, 2, 14'h0400, "R5");       // all
      step(0, 1, NOP, 0, 14'h0000, "R9");       // idle -> pd idle
      step(1, 1, NOP, 0, 14'h0000, "R11");
      step(1, 0, REF, 0, 14'h0000, "R2");
      step(0, 0, REF, 0, 14'h0000, "R10");      // self refresh
      step(0, 1, NOP, 0, 14'h0000, "R10");
      step(1, 1, NOP, 0, 14'h0000, "R11");
      step(1, 0, ACT, 3, 14'h0777, "R3");
      step(0, 0, REF, 0, 14'h0000, "R10");      // open bank: illegal
      step(1, 1, NOP, 0, 14'h0000, "R11");
      step(1, 0, RD,  3, 14'h0405, "R7");
      for (int i = 0; i < BL; i++) step(1, 1, NOP, 0, 14'h0000, "R7");
      step(1, 0, ACT, 2, 14'h0100, "R3");
      step(1, 0, RD,  2, 14'h0008, "R4");
      step(1, 1, NOP, 0, 14'h0000, "R12");
      step(0, 1, NOP, 0, 14'h0000, "R12");      // drop mid-burst
      step(1, 1, NOP, 0, 14'h0000, "R11");
      step(1, 0, PRE, 0, 14'h0400, "R5");

      for (int n = 0; n < 3000; n++) begin
         bit          k = ($urandom % 10) != 0;
         bit          c = ($urandom % 8) == 0;
         bit [2:0]    rcw = 3'($urandom);
         bit [1:0]    b = 2'($urandom);
         bit [13:0]   a = 14'($urandom);
         step(k, c, rcw, b, a, "RND");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule